// File: doc/BRIEF.md
# Six-Compare Dual-Output PWM Channel

This block is a single PWM channel built around a 16-bit up-counter. The counter's values are treated as signed. The counter starts at a programmable start value and steps up to a programmable terminal value, then returns to the start value. Six compare registers sit alongside the counter:

- One compare register marks the terminal value, which sets the period.
- One marks a mid-cycle point.
- Two place the set and clear edges of output A.
- Two place the set and clear edges of output B.

Because edges are placed by compares on a signed count, the same hardware can produce edge-aligned or center-aligned waveforms, either symmetric about zero or not. Two trigger pins pulse on enabled groups of compare matches.

Software programs the block through a write-only register port. The start value and the six compares are written into shadow copies. They only reach the working copies after a load-OK request, and only at the reload point of a running cycle, or at once while the counter is stopped. Further controls are a power-of-two clock prescaler, a run bit, and an enable bit and a polarity bit per output.

The write port follows valid/ready rules. A write is taken on a clock edge where `wr_valid` and `wr_ready` are both high. The block never applies back-pressure: `wr_ready` is always high.

Top module: `pwm_sub6`

## Requirements
- R1: While running, the count rises by one on each counter tick. On the tick where the count equals the terminal compare (address 2), it returns to the start value (address 0). Equality is over all 16 bits, so signed negative values work.
- R2: With prescale field p (CTRL bits [3:1]), a counter tick occurs once every 2^p clocks. After run is set, the start value is held for the first 2^p clocks.
- R3: A compare match is taken on a tick. Output A's state goes active on the clock after a match on address 3 and inactive on the clock after a match on address 4. B does the same with addresses 5 and 6. If the set and clear compares are equal, clear wins.
- R4: trig0 is a one-clock pulse, on the clock after a tick, when any of compares 0, 2 or 4 (addresses 1, 3, 5) matches with its enable set. trig1 does the same for compares 1, 3 and 5 (addresses 2, 4, 6). Enable bit i of the TRIG register (address 8) gates compare i.
- R5: Writes to addresses 0–6 go to shadow copies only. Without a load-OK request the running waveform is unchanged.
- R6: Writing address 9 with bit 0 set raises load-OK. Load-OK copies all shadows to the working registers:
  - while running, on the reload tick;
  - while stopped, on the next clock, and the count then shows the new start value.
  The copy clears load-OK.
- R7: Output pin = enable ? (state XOR polarity) : polarity. CTRL bits 4 and 5 are the enables of A and B; bits 6 and 7 are their polarities.
- R8: With run (CTRL bit 0) clear, the count holds the start value, both output states are inactive, and no trigger pulses.
- R9: After reset, all registers are zero: count 0, pins low, triggers low, `wr_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write accepted (always high) |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Write data |
| count | output | 16 | Current counter value (two's complement) |
| pwm_a | output | 1 | Output A pin |
| pwm_b | output | 1 | Output B pin |
| trig0 | output | 1 | Trigger from compares 0, 2, 4 |
| trig1 | output | 1 | Trigger from compares 1, 3, 5 |

## Verification
The hardest case is a load-OK request that lands in the middle of a running period. The new compare value must not appear until the reload tick, and a shadow write without load-OK must never appear at all. To reach this, the bench keeps the counter running. At a counted clock after run rises, it writes a new clear compare, then raises load-OK on the next clock. Its expected waveform switches to the new value exactly at the first reload after that. A twin pass performs the same write but omits load-OK and expects no change.

// File: rtl/pwm_sub6_pkg.sv
package pwm_sub6_pkg;
  localparam int ADDR_W = 4;
  localparam int NCMP   = 6;
  localparam logic [ADDR_W-1:0] ADDR_INIT = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_VAL0 = 4'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 4'd7;
  localparam logic [ADDR_W-1:0] ADDR_TRIG = 4'd8;
  localparam logic [ADDR_W-1:0] ADDR_LOAD = 4'd9;
  // compare index groups feeding each trigger
  localparam logic [NCMP-1:0] TRIG0_MASK = 6'b010101;
  localparam logic [NCMP-1:0] TRIG1_MASK = 6'b101010;
  localparam int IDX_TERM = 1;
  localparam int IDX_ASET = 2;
  localparam int IDX_ACLR = 3;
  localparam int IDX_BSET = 4;
  localparam int IDX_BCLR = 5;
endpackage

// File: rtl/pwm_sub6_regs.sv
module pwm_sub6_regs
  import pwm_sub6_pkg::*;
#(
  parameter int CW  = 16,
  parameter int PSW = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_valid,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [CW-1:0]            wr_data,
  input  logic                     reload,
  output logic                     run,
  output logic [PSW-1:0]           prescale,
  output logic                     en_a,
  output logic                     en_b,
  output logic                     pol_a,
  output logic                     pol_b,
  output logic [NCMP-1:0]          trig_en,
  output logic [NCMP-1:0][CW-1:0]  val_act,
  output logic [CW-1:0]            init_act,
  output logic [CW-1:0]            init_next,
  output logic                     load_ok
);
  localparam int EA_BIT = PSW + 1;
  localparam int EB_BIT = PSW + 2;
  localparam int PA_BIT = PSW + 3;
  localparam int PB_BIT = PSW + 4;

  logic [CW-1:0]           init_buf;
  logic [NCMP-1:0][CW-1:0] val_buf;
  logic                    xfer;
  logic                    load_set;

  assign xfer      = load_ok && (reload || !run);
  assign load_set  = wr_valid && (wr_addr == ADDR_LOAD) && wr_data[0];
  assign init_next = xfer ? init_buf : init_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_buf <= '0;
      val_buf  <= '0;
      init_act <= '0;
      val_act  <= '0;
      run      <= 1'b0;
      prescale <= '0;
      en_a     <= 1'b0;
      en_b     <= 1'b0;
      pol_a    <= 1'b0;
      pol_b    <= 1'b0;
      trig_en  <= '0;
      load_ok  <= 1'b0;
    end else begin
      if (xfer) begin
        init_act <= init_buf;
        val_act  <= val_buf;
      end
      if (wr_valid) begin
        if (wr_addr == ADDR_INIT) init_buf <= wr_data;
        for (int i = 0; i < NCMP; i++) begin
          if (wr_addr == ADDR_VAL0 + ADDR_W'(i)) val_buf[i] <= wr_data;
        end
        if (wr_addr == ADDR_CTRL) begin
          run      <= wr_data[0];
          prescale <= wr_data[PSW:1];
          en_a     <= wr_data[EA_BIT];
          en_b     <= wr_data[EB_BIT];
          pol_a    <= wr_data[PA_BIT];
          pol_b    <= wr_data[PB_BIT];
        end
        if (wr_addr == ADDR_TRIG) trig_en <= wr_data[NCMP-1:0];
      end
      if (load_set)  load_ok <= 1'b1;
      else if (xfer) load_ok <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_sub6_cnt.sv
module pwm_sub6_cnt #(
  parameter int CW  = 16,
  parameter int PSW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic [PSW-1:0] prescale,
  input  logic [CW-1:0]  init_next,
  input  logic [CW-1:0]  term,
  output logic [CW-1:0]  count,
  output logic           tick,
  output logic           reload
);
  localparam int PCW = (1 << PSW) - 1;

  logic [PCW-1:0] pre_cnt;
  logic [PCW:0]   limit;

  assign limit  = ({{PCW{1'b0}}, 1'b1} << prescale) - 1'b1;
  assign tick   = run && (pre_cnt == limit[PCW-1:0]);
  assign reload = tick && (count == term);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      count   <= '0;
    end else if (!run) begin
      pre_cnt <= '0;
      count   <= init_next;
    end else begin
      pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
      if (reload)    count <= init_next;
      else if (tick) count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_sub6_cmp.sv
module pwm_sub6_cmp
  import pwm_sub6_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic                    tick,
  input  logic [CW-1:0]           count,
  input  logic [NCMP-1:0][CW-1:0] vals,
  input  logic [NCMP-1:0]         trig_en,
  output logic                    a_state,
  output logic                    b_state,
  output logic                    trig0,
  output logic                    trig1
);
  logic [NCMP-1:0] match;

  for (genvar g = 0; g < NCMP; g++) begin : g_match
    assign match[g] = tick && (count == vals[g]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      a_state <= 1'b0;
      b_state <= 1'b0;
      trig0   <= 1'b0;
      trig1   <= 1'b0;
    end else begin
      trig0 <= |(match & trig_en & TRIG0_MASK);
      trig1 <= |(match & trig_en & TRIG1_MASK);
      if (match[IDX_ACLR])      a_state <= 1'b0;
      else if (match[IDX_ASET]) a_state <= 1'b1;
      if (match[IDX_BCLR])      b_state <= 1'b0;
      else if (match[IDX_BSET]) b_state <= 1'b1;
    end
  end
endmodule

// File: rtl/pwm_sub6.sv
module pwm_sub6
  import pwm_sub6_pkg::*;
#(
  parameter int CW  = 16,
  parameter int PSW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CW-1:0]     wr_data,
  output logic [CW-1:0]     count,
  output logic              pwm_a,
  output logic              pwm_b,
  output logic              trig0,
  output logic              trig1
);
  logic                    run, en_a, en_b, pol_a, pol_b, load_ok;
  logic                    tick, reload, a_state, b_state;
  logic [PSW-1:0]          prescale;
  logic [NCMP-1:0]         trig_en;
  logic [NCMP-1:0][CW-1:0] val_act;
  logic [CW-1:0]           init_act, init_next;

  assign wr_ready = 1'b1;

  pwm_sub6_regs #(.CW(CW), .PSW(PSW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .reload(reload), .run(run), .prescale(prescale),
    .en_a(en_a), .en_b(en_b), .pol_a(pol_a), .pol_b(pol_b),
    .trig_en(trig_en), .val_act(val_act), .init_act(init_act),
    .init_next(init_next), .load_ok(load_ok)
  );

  pwm_sub6_cnt #(.CW(CW), .PSW(PSW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .prescale(prescale),
    .init_next(init_next), .term(val_act[IDX_TERM]), .count(count),
    .tick(tick), .reload(reload)
  );

  pwm_sub6_cmp #(.CW(CW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .count(count),
    .vals(val_act), .trig_en(trig_en), .a_state(a_state),
    .b_state(b_state), .trig0(trig0), .trig1(trig1)
  );

  assign pwm_a = en_a ? (a_state ^ pol_a) : pol_a;
  assign pwm_b = en_b ? (b_state ^ pol_b) : pol_b;
endmodule

// File: rtl/pwm_sub6_chk.sv
module pwm_sub6_chk
  import pwm_sub6_pkg::*;
#(
  parameter int CW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              tick,
  input logic              reload,
  input logic              load_ok,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [CW-1:0]     wr_data,
  input logic [CW-1:0]     count,
  input logic              a_state,
  input logic              b_state,
  input logic              trig0,
  input logic              trig1
);
  logic load_wr;
  assign load_wr = wr_valid && (wr_addr == ADDR_LOAD) && wr_data[0];

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !reload) |=> (count == $past(count) + 1'b1));

  assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> (count == $past(count)));

  assert_no_trig_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!trig0 && !trig1));

  assert_ldok_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ok && reload && !load_wr) |=> !load_ok);

  assert_idle_inactive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!a_state && !b_state));
endmodule

bind pwm_sub6 pwm_sub6_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .reload(reload),
  .load_ok(load_ok), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .wr_data(wr_data), .count(count), .a_state(a_state), .b_state(b_state),
  .trig0(trig0), .trig1(trig1)
);

// File: tb/pwm_sub6_bench.sv
`timescale 1ns/1ps
module pwm_sub6_bench;
  typedef struct packed {
    logic [15:0] cnt;
    logic a, b, t0, t1;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count;
  logic        pwm_a, pwm_b, trig0, trig1;

  int checks = 0;
  int fails = 0;
  bit mon_on = 1'b0;
  int mon_k = 0;
  string tag = "R9";
  exp_t q[$];

  int c_init, c_ps;
  int c_v[6];
  bit [5:0] c_te;
  bit c_ea, c_eb, c_pa, c_pb;

  always #2 clk = ~clk;

  pwm_sub6 u_pwm_sub6 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .count(count), .pwm_a(pwm_a),
    .pwm_b(pwm_b), .trig0(trig0), .trig1(trig1)
  );

  function automatic logic [15:0] ctrl_word(input bit run);
    return 16'(run) | 16'(c_ps << 1) | 16'(c_ea) << 4 | 16'(c_eb) << 5 |
           16'(c_pa) << 6 | 16'(c_pb) << 7;
  endfunction

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  // Monitor: pops one expected item per clock while a pass is running.
  always @(negedge clk) begin
    if (mon_on && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (count !== e.cnt || pwm_a !== e.a || pwm_b !== e.b ||
          trig0 !== e.t0 || trig1 !== e.t1) begin
        fails++;
        $display("FAIL %s k=%0d act cnt=%0d a=%b b=%b t0=%b t1=%b exp cnt=%0d a=%b b=%b t0=%b t1=%b",
                 tag, mon_k, $signed(count), pwm_a, pwm_b, trig0, trig1,
                 $signed(e.cnt), e.a, e.b, e.t0, e.t1);
      end
      mon_k++;
    end
  end

  // Driver-side model of the requirements, pushing one item per clock.
  task automatic build(input int n, input int kw, input bit do_load, input int nv3);
    int cnt, d, v[6];
    bit sa, sb, pt0, pt1, loaded;
    cnt = c_init; sa = 0; sb = 0; pt0 = 0; pt1 = 0; loaded = 0;
    d = 1 << c_ps;
    for (int i = 0; i < 6; i++) v[i] = c_v[i];
    q.delete();
    for (int k = 0; k < n; k++) begin
      exp_t e;
      bit [5:0] m;
      e.cnt = 16'(cnt);
      e.a = c_ea ? (sa ^ c_pa) : c_pa;
      e.b = c_eb ? (sb ^ c_pb) : c_pb;
      e.t0 = pt0; e.t1 = pt1;
      q.push_back(e);
      pt0 = 0; pt1 = 0;
      if (k % d == d - 1) begin
        for (int i = 0; i < 6; i++) m[i] = (16'(cnt) == 16'(v[i]));
        pt0 = |(m & c_te & 6'b010101);
        pt1 = |(m & c_te & 6'b101010);
        if (m[3]) sa = 0; else if (m[2]) sa = 1;
        if (m[5]) sb = 0; else if (m[4]) sb = 1;
        if (16'(cnt) == 16'(v[1])) begin
          cnt = c_init;
          if (do_load && kw >= 0 && k >= kw + 2 && !loaded) begin
            v[3] = nv3; loaded = 1;
          end
        end else cnt = cnt + 1;
      end
    end
  endtask

  task automatic apply_cfg();
    wr(4'd7, ctrl_word(1'b0));
    wr(4'd0, 16'(c_init));
    for (int i = 0; i < 6; i++) wr(4'(i + 1), 16'(c_v[i]));
    wr(4'd8, 16'(c_te));
    wr(4'd9, 16'd1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(count == 16'(c_init),
          $sformatf("R6 stopped load act=%0d exp=%0d", $signed(count), c_init));
  endtask

  task automatic run_pass(input string t, input int n, input int kw,
                          input bit do_load, input int nv3);
    tag = t;
    mon_k = 0;
    build(n, kw, do_load, nv3);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 4'd7; wr_data = ctrl_word(1'b1);
    @(posedge clk); #1;
    wr_valid = 1'b0;
    mon_on = 1'b1;
    for (int k = 0; k <= n; k++) begin
      @(negedge clk);
      if (k == kw) begin
        wr_valid = 1'b1; wr_addr = 4'd4; wr_data = 16'(nv3);
      end else if (k == kw + 1 && do_load) begin
        wr_valid = 1'b1; wr_addr = 4'd9; wr_data = 16'd1;
      end else wr_valid = 1'b0;
    end
    wr_valid = 1'b0;
    mon_on = 1'b0;
    // stop and check idle levels
    wr(4'd7, ctrl_word(1'b0));
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(count == 16'(c_init) && pwm_a == c_pa && pwm_b == c_pb && !trig0 && !trig1,
          $sformatf("R8 stop act cnt=%0d a=%b b=%b exp cnt=%0d a=%b b=%b",
                    $signed(count), pwm_a, pwm_b, c_init, c_pa, c_pb));
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(count == 0 && !pwm_a && !pwm_b && !trig0 && !trig1 && wr_ready,
          $sformatf("R9 reset act cnt=%0d a=%b b=%b t=%b%b rdy=%b exp 0 0 0 00 1",
                    count, pwm_a, pwm_b, trig0, trig1, wr_ready));

    // Edge-aligned unsigned, all triggers
    c_init = 0; c_v = '{5, 9, 0, 4, 2, 7}; c_te = 6'b111111; c_ps = 0;
    c_ea = 1; c_eb = 1; c_pa = 0; c_pb = 0;
    apply_cfg();
    run_pass("R1 R3 R4 edge", 30, -1, 0, 0);

    // Signed symmetric count, partial trigger enables, B inverted
    c_init = -5; c_v = '{0, 4, -2, 2, -3, 3}; c_te = 6'b000101; c_ps = 0;
    c_ea = 1; c_eb = 1; c_pa = 0; c_pb = 1;
    apply_cfg();
    run_pass("R1 R4 R7 signed", 30, -1, 0, 0);

    // Prescale by 4, B set==clear so clear wins
    c_init = 0; c_v = '{2, 3, 1, 2, 0, 0}; c_te = 6'b100010; c_ps = 2;
    c_ea = 1; c_eb = 1; c_pa = 0; c_pb = 0;
    apply_cfg();
    run_pass("R2 R3 prescale", 40, -1, 0, 0);

    // A disabled with polarity 1
    c_init = 0; c_v = '{5, 9, 0, 4, 2, 7}; c_te = 6'b000000; c_ps = 0;
    c_ea = 0; c_eb = 1; c_pa = 1; c_pb = 0;
    apply_cfg();
    run_pass("R7 disable", 20, -1, 0, 0);

    // Shadow write without load-OK: no change
    c_ea = 1; c_pa = 0; c_te = 6'b111111;
    apply_cfg();
    run_pass("R5 shadow", 30, 3, 0, 8);

    // Shadow write with load-OK mid-period: takes effect at reload
    apply_cfg();
    run_pass("R6 midrun load", 40, 3, 1, 8);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule